// File: doc/BRIEF.md
# Serial Link Error Status Register

This block holds the per-port error and diagnostic status word of a serial storage host port. Single-cycle event pulses from the physical, link and transport layers set sticky flag bits. Each flag stays set until software writes a one to its position through a simple register write port. The whole word is always visible on a read data output, and reading it has no side effects.

The block watches the PHY-ready level itself and flags any change of that level. A link initialisation indication sets a device-exchange flag. Two of the flags go out as change-status signals for a neighbouring interrupt status block. Any flag in the transfer-halting group (bits 11 down to 8) raises a stop-transfer request to the port's data mover. Three positions of the architected word are never built, and the reserved ranges always read zero.

Top module: `link_err_status`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `csr_rd_data` is 0 and `stop_xfer`, `conn_change` and `phy_ready_change` are low.
- R2: An event pulse sampled at a clock edge sets its flag from that edge on, and the flag stays set with no further pulse. The flag positions are: unrecognised frame type 25, transport state error 24, link sequence error 23, negative handshake 22, CRC error 21, 10b/8b decode error 19, comm wake 18, memory access abort 11, protocol violation 10, unrecovered transient integrity error 8, recovered communication loss 1, recovered integrity error 0.
- R3: A write with `csr_wr_en` high clears every flag whose `csr_wr_data` bit is 1 and leaves every flag whose bit is 0 unchanged.
- R4: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: A `cominit_pulse` sets bit 26, and `conn_change` equals bit 26 at all times.
- R6: A change of `phy_ready` in either direction between two consecutive clock edges sets bit 16, and `phy_ready_change` equals bit 16 at all times.
- R7: A `phy_ready` level that differs from the block's reset-time sample sets no flag at the first clock edge after reset.
- R8: Bits 20, 17 and 9 and the reserved ranges 31:27, 15:12 and 7:2 always read 0, even after all events fire and after writes of all ones.
- R9: `stop_xfer` is high exactly when at least one of bits 11:8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 32 | Write data; each 1 clears the flag at that position |
| csr_rd_data | output | 32 | Current register value |
| phy_ready | input | 1 | PHY-ready level |
| cominit_pulse | input | 1 | Link initialisation received |
| evt_unk_frame | input | 1 | Frame of unrecognised type with good CRC |
| evt_xport_trans | input | 1 | Transport layer state transition error |
| evt_link_seq | input | 1 | Link layer sequence error |
| evt_nak_hs | input | 1 | Negative handshake received for a sent frame |
| evt_crc | input | 1 | CRC error |
| evt_decode | input | 1 | 10b/8b decode error |
| evt_comm_wake | input | 1 | Comm wake detected |
| evt_mem_abort | input | 1 | System memory access aborted |
| evt_protocol | input | 1 | Protocol violation |
| evt_xient_integrity | input | 1 | Unrecovered transient data integrity error |
| evt_recov_comm | input | 1 | Communication lost then re-established |
| evt_recov_integrity | input | 1 | Data integrity error recovered by retry |
| stop_xfer | output | 1 | Request to halt the current transfer |
| conn_change | output | 1 | Connect-change status (bit 26) |
| phy_ready_change | output | 1 | PHY-ready change status (bit 16) |

## Verification
Every cycle, the assertions check that set events win over clears, that write-one-to-clear takes effect and zero bits hold, that a PHY-ready level change always raises the change flag once the watcher is armed, and that halt-group events and link initialisation reach `stop_xfer` and `conn_change` one edge later. Only the bench scenarios show the rest. These are the quiet first edge after reset with PHY-ready already high, the exact flag position of each event, and that unbuilt and reserved positions stay zero under all-ones events and writes. They also show that `stop_xfer` drops once the last halt-group flag is cleared while the recovered-error flags leave it low.

// File: rtl/lerr_pkg.sv
package lerr_pkg;

    localparam int unsigned STAT_W = 32;
    typedef logic [STAT_W-1:0] stat_t;

    // flag positions that neighbours decode
    localparam int unsigned B_EXCH    = 26;
    localparam int unsigned B_UNKFRM  = 25;
    localparam int unsigned B_XPORT   = 24;
    localparam int unsigned B_LSEQ    = 23;
    localparam int unsigned B_NAK     = 22;
    localparam int unsigned B_CRC     = 21;
    localparam int unsigned B_DEC     = 19;
    localparam int unsigned B_WAKE    = 18;
    localparam int unsigned B_PRDY    = 16;
    localparam int unsigned B_MEMABT  = 11;
    localparam int unsigned B_PROTO   = 10;
    localparam int unsigned B_XIENT   = 8;
    localparam int unsigned B_RCOMM   = 1;
    localparam int unsigned B_RDATA   = 0;

    // group of flags that halts the data mover
    localparam int unsigned HALT_LO = 8;
    localparam int unsigned HALT_HI = 11;

    localparam stat_t LIVE_MASK =
        (stat_t'(1) << B_EXCH)   | (stat_t'(1) << B_UNKFRM) |
        (stat_t'(1) << B_XPORT)  | (stat_t'(1) << B_LSEQ)   |
        (stat_t'(1) << B_NAK)    | (stat_t'(1) << B_CRC)    |
        (stat_t'(1) << B_DEC)    | (stat_t'(1) << B_WAKE)   |
        (stat_t'(1) << B_PRDY)   | (stat_t'(1) << B_MEMABT) |
        (stat_t'(1) << B_PROTO)  | (stat_t'(1) << B_XIENT)  |
        (stat_t'(1) << B_RCOMM)  | (stat_t'(1) << B_RDATA);

    typedef struct packed {
        logic lvl;
        logic armed;
    } phy_watch_t;

endpackage

// File: rtl/lerr_phy_watch.sv
module lerr_phy_watch
    import lerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phy_ready,
    output logic lvl_chg
);

    phy_watch_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lvl   = phy_ready;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // no event until one real sample has been taken after reset
    assign lvl_chg = st_q.armed & (phy_ready ^ st_q.lvl);

    assert_level_change_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && (phy_ready != $past(phy_ready))) |-> lvl_chg);

endmodule

// File: rtl/lerr_event_map.sv
module lerr_event_map
    import lerr_pkg::*;
(
    input  logic  cominit_pulse,
    input  logic  prdy_chg,
    input  logic  evt_unk_frame,
    input  logic  evt_xport_trans,
    input  logic  evt_link_seq,
    input  logic  evt_nak_hs,
    input  logic  evt_crc,
    input  logic  evt_decode,
    input  logic  evt_comm_wake,
    input  logic  evt_mem_abort,
    input  logic  evt_protocol,
    input  logic  evt_xient_integrity,
    input  logic  evt_recov_comm,
    input  logic  evt_recov_integrity,
    output stat_t set_vec
);

    always_comb begin
        set_vec           = '0;
        set_vec[B_EXCH]   = cominit_pulse;
        set_vec[B_UNKFRM] = evt_unk_frame;
        set_vec[B_XPORT]  = evt_xport_trans;
        set_vec[B_LSEQ]   = evt_link_seq;
        set_vec[B_NAK]    = evt_nak_hs;
        set_vec[B_CRC]    = evt_crc;
        set_vec[B_DEC]    = evt_decode;
        set_vec[B_WAKE]   = evt_comm_wake;
        set_vec[B_PRDY]   = prdy_chg;
        set_vec[B_MEMABT] = evt_mem_abort;
        set_vec[B_PROTO]  = evt_protocol;
        set_vec[B_XIENT]  = evt_xient_integrity;
        set_vec[B_RCOMM]  = evt_recov_comm;
        set_vec[B_RDATA]  = evt_recov_integrity;
    end

endmodule

// File: rtl/lerr_sticky_bank.sv
module lerr_sticky_bank #(
    parameter int unsigned         W    = 32,
    parameter logic [W-1:0]        MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] bits_q
);

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        if (MASK[gi]) begin : g_live
            logic b_d, b_q;
            // set has priority over a same-cycle clear
            always_comb b_d = set_vec[gi] | (b_q & ~(clr_en & clr_vec[gi]));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) b_q <= 1'b0;
                else        b_q <= b_d;
            end
            assign bits_q[gi] = b_q;
        end else begin : g_tied
            logic unused_in;
            assign unused_in  = set_vec[gi] ^ clr_vec[gi];
            assign bits_q[gi] = 1'b0;
        end
    end

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((bits_q & $past(set_vec & MASK)) == $past(set_vec & MASK)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((bits_q & ~$past(set_vec) & ($past(clr_en) ? $past(clr_vec) : '0)) == '0));

    assert_zero_write_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((bits_q ^ $past(bits_q)) & ~$past(set_vec)
                    & ~($past(clr_en) ? $past(clr_vec) : '0)) == '0));

endmodule

// File: rtl/link_err_status.sv
module link_err_status
    import lerr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr_en,
    input  logic [31:0] csr_wr_data,
    output logic [31:0] csr_rd_data,
    input  logic        phy_ready,
    input  logic        cominit_pulse,
    input  logic        evt_unk_frame,
    input  logic        evt_xport_trans,
    input  logic        evt_link_seq,
    input  logic        evt_nak_hs,
    input  logic        evt_crc,
    input  logic        evt_decode,
    input  logic        evt_comm_wake,
    input  logic        evt_mem_abort,
    input  logic        evt_protocol,
    input  logic        evt_xient_integrity,
    input  logic        evt_recov_comm,
    input  logic        evt_recov_integrity,
    output logic        stop_xfer,
    output logic        conn_change,
    output logic        phy_ready_change
);

    logic  prdy_chg;
    stat_t set_vec;
    stat_t stat_q;

    lerr_phy_watch u_phy_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_ready (phy_ready),
        .lvl_chg   (prdy_chg)
    );

    lerr_event_map u_event_map (
        .cominit_pulse       (cominit_pulse),
        .prdy_chg            (prdy_chg),
        .evt_unk_frame       (evt_unk_frame),
        .evt_xport_trans     (evt_xport_trans),
        .evt_link_seq        (evt_link_seq),
        .evt_nak_hs          (evt_nak_hs),
        .evt_crc             (evt_crc),
        .evt_decode          (evt_decode),
        .evt_comm_wake       (evt_comm_wake),
        .evt_mem_abort       (evt_mem_abort),
        .evt_protocol        (evt_protocol),
        .evt_xient_integrity (evt_xient_integrity),
        .evt_recov_comm      (evt_recov_comm),
        .evt_recov_integrity (evt_recov_integrity),
        .set_vec             (set_vec)
    );

    lerr_sticky_bank #(
        .W    (STAT_W),
        .MASK (LIVE_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_en  (csr_wr_en),
        .clr_vec (csr_wr_data),
        .bits_q  (stat_q)
    );

    assign csr_rd_data      = stat_q;
    assign stop_xfer        = |stat_q[HALT_HI:HALT_LO];
    assign conn_change      = stat_q[B_EXCH];
    assign phy_ready_change = stat_q[B_PRDY];

    assert_halt_event_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mem_abort || evt_protocol || evt_xient_integrity) |=> stop_xfer);

    assert_cominit_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cominit_pulse |=> conn_change);

endmodule

// File: tb/link_err_status_tb.sv
`timescale 1ns/1ps
module link_err_status_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_wr_en;
    logic [31:0] csr_wr_data;
    logic [31:0] csr_rd_data;
    logic        phy_ready, cominit_pulse;
    logic        evt_unk_frame, evt_xport_trans, evt_link_seq, evt_nak_hs, evt_crc;
    logic        evt_decode, evt_comm_wake, evt_mem_abort, evt_protocol;
    logic        evt_xient_integrity, evt_recov_comm, evt_recov_integrity;
    logic        stop_xfer, conn_change, phy_ready_change;

    always #2.5 clk = ~clk;

    link_err_status u_dut (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
        .csr_rd_data(csr_rd_data), .phy_ready(phy_ready), .cominit_pulse(cominit_pulse),
        .evt_unk_frame(evt_unk_frame), .evt_xport_trans(evt_xport_trans),
        .evt_link_seq(evt_link_seq), .evt_nak_hs(evt_nak_hs), .evt_crc(evt_crc),
        .evt_decode(evt_decode), .evt_comm_wake(evt_comm_wake),
        .evt_mem_abort(evt_mem_abort), .evt_protocol(evt_protocol),
        .evt_xient_integrity(evt_xient_integrity), .evt_recov_comm(evt_recov_comm),
        .evt_recov_integrity(evt_recov_integrity), .stop_xfer(stop_xfer),
        .conn_change(conn_change), .phy_ready_change(phy_ready_change)
    );

    // flags that exist, from the requirements (R2, R5, R6, R8)
    localparam logic [31:0] LIVE = 32'h07ED_0D03;

    int          vectors = 0;
    int          miscompares = 0;
    bit          finished = 1'b0;
    logic [31:0] q_exp[$];
    string       q_tag[$];
    logic [31:0] model = '0;
    logic        prev_phy = 1'b0;
    bit          armed = 1'b0;

    // driver: apply one cycle of stimulus, predict, queue expectation
    task automatic drive(input logic [31:0] ev, input logic we, input logic [31:0] wd,
                         input logic phy, input string tag);
        logic [31:0] setv;
        @(negedge clk);
        cominit_pulse       = ev[26];
        evt_unk_frame       = ev[25];
        evt_xport_trans     = ev[24];
        evt_link_seq        = ev[23];
        evt_nak_hs          = ev[22];
        evt_crc             = ev[21];
        evt_decode          = ev[19];
        evt_comm_wake       = ev[18];
        evt_mem_abort       = ev[11];
        evt_protocol        = ev[10];
        evt_xient_integrity = ev[8];
        evt_recov_comm      = ev[1];
        evt_recov_integrity = ev[0];
        csr_wr_en           = we;
        csr_wr_data         = wd;
        phy_ready           = phy;
        setv = ev & LIVE & ~(32'h1 << 16);
        if (armed && (phy != prev_phy)) setv[16] = 1'b1;
        armed    = 1'b1;
        prev_phy = phy;
        model = (setv | (model & ~(we ? wd : 32'h0))) & LIVE;
        @(posedge clk);
        q_exp.push_back(model);
        q_tag.push_back(tag);
    endtask

    // monitor: compare outputs half a cycle after each edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            vectors++;
            if (csr_rd_data !== e || stop_xfer !== (|e[11:8]) ||
                conn_change !== e[26] || phy_ready_change !== e[16]) begin
                miscompares++;
                $display("FAIL %s: rd=%h stop=%b conn=%b prc=%b expected rd=%h stop=%b conn=%b prc=%b",
                         t, csr_rd_data, stop_xfer, conn_change, phy_ready_change,
                         e, |e[11:8], e[26], e[16]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int unsigned pos_list[12] = '{25, 24, 23, 22, 21, 19, 18, 11, 10, 8, 1, 0};
        rst_n = 1'b0; csr_wr_en = 1'b0; csr_wr_data = '0; phy_ready = 1'b1;
        cominit_pulse = 0; evt_unk_frame = 0; evt_xport_trans = 0; evt_link_seq = 0;
        evt_nak_hs = 0; evt_crc = 0; evt_decode = 0; evt_comm_wake = 0;
        evt_mem_abort = 0; evt_protocol = 0; evt_xient_integrity = 0;
        evt_recov_comm = 0; evt_recov_integrity = 0;
        repeat (3) @(posedge clk);
        q_exp.push_back(32'h0); q_tag.push_back("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R7: first edge after reset with phy_ready already high
        @(posedge clk);
        q_exp.push_back(32'h0); q_tag.push_back("R7 first edge");
        armed = 1'b1; prev_phy = 1'b1;
        drive('0, 0, '0, 1, "R1 idle after reset");

        // R2 each event sets its own flag and holds; R3 clear it
        foreach (pos_list[i]) begin
            drive(32'h1 << pos_list[i], 0, '0, 1, "R2 set");
            drive('0, 0, '0, 1, "R2 sticky");
            drive('0, 1, 32'h1 << pos_list[i], 1, "R3 clear");
        end

        // R3 partial clears and zero writes
        drive((32'h1 << 25) | (32'h1 << 21) | 32'h1, 0, '0, 1, "R2 multi");
        drive('0, 1, 32'h1 << 21, 1, "R3 clear one");
        drive('0, 1, 32'h0, 1, "R3 zero write");
        drive('0, 0, 32'hFFFF_FFFF, 1, "R3 no strobe");
        drive('0, 1, 32'hFFFF_FFFF, 1, "R3 clear all");

        // R4 set and clear in the same cycle
        drive(32'h1 << 23, 1, 32'h1 << 23, 1, "R4 collide");
        drive('0, 0, '0, 1, "R4 held");
        drive('0, 1, 32'h1 << 23, 1, "R4 cleanup");

        // R5 link initialisation
        drive(32'h1 << 26, 0, '0, 1, "R5 cominit");
        drive('0, 1, 32'h1 << 26, 1, "R5 clear");

        // R6 phy ready falls, holds, rises
        drive('0, 0, '0, 0, "R6 fall");
        drive('0, 0, '0, 0, "R6 steady low");
        drive('0, 1, 32'h1 << 16, 0, "R6 clear");
        drive('0, 0, '0, 0, "R6 no re-set");
        drive('0, 0, '0, 1, "R6 rise");
        drive('0, 1, 32'h1 << 16, 0, "R4 prdy collide");
        drive('0, 1, 32'h1 << 16, 0, "R6 clear");

        // R8 unbuilt and reserved positions
        drive(32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 0, "R8 all events");
        drive('0, 0, '0, 0, "R8 read");
        drive('0, 1, 32'hFFFF_FFFF, 0, "R8 clear all");
        drive('0, 1, 32'hFFFF_FFFF, 0, "R8 idle zero");

        // R9 stop request follows the halt group
        drive(32'h3, 0, '0, 0, "R9 recovered only");
        drive(32'h1 << 8, 0, '0, 0, "R9 transient");
        drive(32'h1 << 11, 1, 32'h1 << 8, 0, "R9 swap");
        drive('0, 1, 32'h1 << 11, 0, "R9 drop");
        drive(32'h1 << 10, 0, '0, 0, "R9 protocol");
        drive('0, 1, 32'hFFFF_FFFF, 0, "R9 clear");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule